// File: doc/BRIEF.md
# Power switch pair control and status register

This block holds the control state for a pair of power switches of the same kind and turns it into two switch-enable outputs. Each switch has an on/off bit and a PWM-enable bit. When PWM control is enabled for a switch that is on, its output follows a shared external PWM input after that input has been synchronised. When PWM control is disabled, the on/off bit alone drives the output.

A serial interface writes a 4-bit control nibble with a write strobe. Each write, and each plain read, returns a 4-bit status nibble. That status carries open-load and current-limit flags per switch, sampled every cycle. A thermal fault on the group sets all four status bits at once, forces both outputs off in the cycle it appears, and clears the control nibble. The control nibble is also cleared by a reset-mode request, by an external reset, and by a supply overvoltage while overvoltage shutdown is enabled.

Top module: `sw_drv_regs`

## Requirements
- R1: After rst_ni is asserted, the control nibble is 0, both sw_o bits are 0 and rsp_o is 0.
- R2: A write (wr_i high for one cycle) loads wdata_i into the control nibble. Bit 0 is switch 1 on/off, bit 1 is switch 2 on/off, bit 2 is switch 1 PWM-enable and bit 3 is switch 2 PWM-enable. sw_o[0] is switch 1 and sw_o[1] is switch 2.
- R3: If a switch is on and its PWM-enable bit is 1, its sw_o bit equals pwm_i as it was two clock edges earlier. If the PWM-enable bit is 0, the output is simply on.
- R4: If a switch's on/off bit is 0, its sw_o bit is 0 whatever pwm_i and the PWM-enable bit are.
- R5: On a write, rsp_o takes the status nibble as it stood before that edge. This is the fault inputs sampled at the previous edge, not the effect of the new control value.
- R6: A read (rd_i) loads the status nibble into rsp_o and leaves the control nibble unchanged.
- R7: The status nibble is {ol_i[1], cl_i[1], ol_i[0], cl_i[0]} (bit 3 down to bit 0), registered once per cycle.
- R8: While any ot_i bit is 1, the status sampled at that edge is 4'b1111.
- R9: Any ot_i bit at 1 forces both sw_o bits to 0 in the same cycle, and clears the control nibble at the next edge.
- R10: vs_ov_i together with hv_shdn_en_i clears the control nibble. vs_ov_i alone has no effect.
- R11: mode_rst_i or ext_rst_i clears the control nibble.
- R12: When a clear condition and a write fall on the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Control register write strobe |
| rd_i | input | 1 | Status read strobe |
| wdata_i | input | 4 | Control nibble to write |
| rsp_o | output | 4 | Status nibble returned by the last write or read |
| pwm_i | input | 1 | Shared asynchronous PWM input |
| ol_i | input | 2 | Open-load flag per switch |
| cl_i | input | 2 | Current-limit flag per switch |
| ot_i | input | 2 | Over-temperature flag per switch |
| vs_ov_i | input | 1 | Supply overvoltage flag |
| hv_shdn_en_i | input | 1 | Enables clearing on overvoltage |
| mode_rst_i | input | 1 | Reset-mode entry request |
| ext_rst_i | input | 1 | External reset request |
| sw_o | output | 2 | Switch enable outputs |

## Verification
A write can land on the same edge as a clear event. It can also land on the same edge as a change on the fault flags. The bench stages both coincidences. It raises over-temperature, qualified overvoltage and reset requests together with a write strobe, then judges at the outputs that both switches stay off with a nibble that would otherwise turn them on. It also changes ol_i and cl_i on the edge of a write and expects rsp_o to carry the flags from before that edge.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned N_SW = 2;
  localparam int unsigned CW   = 2 * N_SW;
  typedef logic [CW-1:0] nib_t;
endpackage

// File: rtl/sw_pwm_sync.sv
module sw_pwm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sw_ctl_reg.sv
module sw_ctl_reg
  import sw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  nib_t wdata_i,
  input  logic clr_i,
  output nib_t ctl_o
);
  nib_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (clr_i) ctl_q <= '0;
    else if (wr_i)  ctl_q <= wdata_i;
  end

  assign ctl_o = ctl_q;

  a_r12_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ctl_q == '0);
  a_r2_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> ctl_q == $past(wdata_i));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !clr_i) |=> $stable(ctl_q));
endmodule

// File: rtl/sw_stat_cap.sv
module sw_stat_cap
  import sw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SW-1:0]   ol_i,
  input  logic [N_SW-1:0]   cl_i,
  input  logic              therm_i,
  input  logic              acc_i,
  output nib_t              rsp_o
);
  nib_t raw, stat_q, rsp_q;

  for (genvar i = 0; i < N_SW; i++) begin : g_pair
    assign raw[2*i+1] = ol_i[i];
    assign raw[2*i]   = cl_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      rsp_q  <= '0;
    end else begin
      stat_q <= therm_i ? '1 : raw;
      if (acc_i) rsp_q <= stat_q;
    end
  end

  assign rsp_o = rsp_q;

  a_r8_therm_all_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_i |=> stat_q == '1);
  a_r5_rsp_prior: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> rsp_q == $past(stat_q));
endmodule

// File: rtl/sw_out_gate.sv
module sw_out_gate
  import sw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  nib_t            ctl_i,
  input  logic            pwm_i,
  input  logic            therm_i,
  output logic [N_SW-1:0] sw_o
);
  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    logic on, pen;
    assign on   = ctl_i[i];
    assign pen  = ctl_i[N_SW+i];
    assign sw_o[i] = on && !therm_i && (pen ? pwm_i : 1'b1);

    a_r4_off_when_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !on |-> !sw_o[i]);
  end

  a_r9_therm_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_i |-> sw_o == '0);
endmodule

// File: rtl/sw_drv_regs.sv
module sw_drv_regs
  import sw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [3:0] wdata_i,
  output logic [3:0] rsp_o,
  input  logic       pwm_i,
  input  logic [1:0] ol_i,
  input  logic [1:0] cl_i,
  input  logic [1:0] ot_i,
  input  logic       vs_ov_i,
  input  logic       hv_shdn_en_i,
  input  logic       mode_rst_i,
  input  logic       ext_rst_i,
  output logic [1:0] sw_o
);
  logic therm, clr, pwm_s;
  nib_t ctl;

  assign therm = |ot_i;
  assign clr   = therm | mode_rst_i | ext_rst_i | (vs_ov_i & hv_shdn_en_i);

  sw_pwm_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwm_i), .q_o(pwm_s)
  );

  sw_ctl_reg u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .clr_i(clr), .ctl_o(ctl)
  );

  sw_stat_cap u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .ol_i(ol_i), .cl_i(cl_i),
    .therm_i(therm), .acc_i(wr_i | rd_i), .rsp_o(rsp_o)
  );

  sw_out_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl), .pwm_i(pwm_s),
    .therm_i(therm), .sw_o(sw_o)
  );

  a_r10_ov_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_ov_i && hv_shdn_en_i) |=> sw_o == '0 || ot_i != '0 || $past(wr_i));
endmodule

// File: tb/sim_sw_drv_regs.sv
module sim_sw_drv_regs;
  logic clk = 0, rst_ni = 0;
  logic wr = 0, rd = 0, pwm = 0, vs_ov = 0, hv_en = 0, mrst = 0, erst = 0;
  logic [3:0] wdata = 0, rsp;
  logic [1:0] ol = 0, cl = 0, ot = 0, sw;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sw_drv_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rsp_o(rsp), .pwm_i(pwm), .ol_i(ol), .cl_i(cl), .ot_i(ot),
    .vs_ov_i(vs_ov), .hv_shdn_en_i(hv_en), .mode_rst_i(mrst),
    .ext_rst_i(erst), .sw_o(sw)
  );

  // {wdata[3:0], pwm, exp_sw[1:0]}
  localparam logic [6:0] VEC [10] = '{
    7'b0001_0_01, 7'b0001_1_01, 7'b0010_0_10, 7'b0011_1_11, 7'b0101_0_00,
    7'b0101_1_01, 7'b1111_0_00, 7'b1011_0_01, 7'b1100_1_00, 7'b1010_1_10
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write(input logic [3:0] d);
    wdata = d; wr = 1; tick(); wr = 0;
  endtask

  task automatic read();
    rd = 1; tick(); rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 sw", {2'b0, sw}, 4'h0);
    chk("R1 rsp", rsp, 4'h0);
    rst_ni = 1; tick();

    for (int i = 0; i < 10; i++) begin
      pwm = VEC[i][2];
      write(VEC[i][6:3]);
      tick(); tick();
      chk($sformatf("R2/R3/R4 vec%0d", i), {2'b0, sw}, {2'b0, VEC[i][1:0]});
    end

    // R3 sync latency: sw1 PWM-enabled and on
    pwm = 0; write(4'b0101); tick(); tick();
    pwm = 1; tick();
    chk("R3 one edge", {2'b0, sw}, 4'h0);
    tick();
    chk("R3 two edges", {2'b0, sw}, 4'h1);

    // R7 status layout via read, R6 read keeps control
    write(4'b0011);
    ol = 2'b10; cl = 2'b01; tick();
    read();
    chk("R7 layout", rsp, 4'b1001);
    chk("R6 ctl kept", {2'b0, sw}, 4'b0011);

    // R5 flags change on the write edge, response shows prior status
    ol = 2'b01; cl = 2'b00; tick();
    ol = 2'b00; cl = 2'b10; write(4'b0011);
    chk("R5 prior status", rsp, 4'b0010);
    read();
    chk("R7 new status", rsp, 4'b0100);
    ol = 0; cl = 0;

    // R9/R8 thermal
    write(4'b0011); tick();
    ot = 2'b10; #1;
    chk("R9 same cycle off", {2'b0, sw}, 4'h0);
    tick(); ot = 0; tick();
    chk("R9 ctl cleared", {2'b0, sw}, 4'h0);
    ot = 2'b01; tick(); ot = 0;
    read();
    chk("R8 all set", rsp, 4'hF);

    // R12 thermal coincides with write
    ot = 2'b01; write(4'b0011); ot = 0; tick();
    chk("R12 therm beats write", {2'b0, sw}, 4'h0);

    // R10 overvoltage qualified / unqualified
    write(4'b0011);
    vs_ov = 1; hv_en = 0; tick(); tick();
    chk("R10 ov alone no effect", {2'b0, sw}, 4'b0011);
    hv_en = 1; tick(); vs_ov = 0; hv_en = 0; tick();
    chk("R10 ov qualified clears", {2'b0, sw}, 4'h0);
    vs_ov = 1; hv_en = 1; write(4'b0011); vs_ov = 0; hv_en = 0; tick();
    chk("R12 ov beats write", {2'b0, sw}, 4'h0);

    // R11 reset mode / external reset
    write(4'b0011);
    mrst = 1; tick(); mrst = 0;
    chk("R11 mode reset", {2'b0, sw}, 4'h0);
    write(4'b0010);
    erst = 1; write(4'b0011); erst = 0; tick();
    chk("R11/R12 ext reset", {2'b0, sw}, 4'h0);

    // R1 async reset mid-run
    write(4'b0011); read();
    rst_ni = 0; #1;
    chk("R1 async sw", {2'b0, sw}, 4'h0);
    chk("R1 async rsp", rsp, 4'h0);
    tick(); rst_ni = 1; tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule